// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small processor built around a single 16-bit accumulator. Every instruction is one 16-bit word: the upper byte selects the operation and the lower byte names one word of a 256-word, 16-bit memory (direct addressing only). Inside the core sit an 8-bit program counter, an 8-bit memory address register, a 16-bit memory buffer register, an 8-bit opcode register and a 16-bit operand buffer.

No hardwired instruction decoder exists. A 32-bit-wide control store drives every register transfer. A control address register steps through it. After fetch, the opcode is added to the control address. This lands on a jump-table entry, which branches to that instruction's microroutine, and every routine ends by returning the control address to the fetch entry.

The memory sits outside the core. It has a combinational read-data input, a separate write-data output, a read strobe and a write enable. A `halted` output rises while the core spins in the halt microroutine, so a surrounding environment knows when the program has finished.

Top module: `acc_cpu_core`

## Requirements
- R1: A synchronous reset clears the program counter, accumulator and control address. In the cycle after reset is released, the core latches the program counter into the address register. In the following cycle it asserts `mem_rd` with `mem_addr` = 0, so the first instruction comes from word 0.
- R2: An instruction word carries the opcode in bits [15:8] and the operand address in bits [7:0]. Opcode 0x01 writes the accumulator into the addressed word, with exactly one `mem_we` cycle per store.
- R3: Opcode 0x02 leaves the accumulator equal to the addressed word, whatever it held before.
- R4: Opcode 0x03 adds the addressed word to the accumulator, and opcode 0x04 subtracts it. Both keep the result modulo 2^16.
- R5: Opcode 0x06 replaces the accumulator with its bitwise AND with the addressed word. Opcode 0x07 does the same with bitwise OR.
- R6: Opcode 0x08 inverts the accumulator, opcode 0x09 shifts it right one bit with a zero fill, and opcode 0x0A shifts it left one bit with a zero fill. None of these three performs a memory read beyond the instruction fetch.
- R7: Opcode 0x0B multiplies the accumulator by the addressed word and keeps the low 16 bits of the product.
- R8: Opcode 0x05 loads the address field into the program counter when accumulator bit 15 is 0, zero included. When bit 15 is 1 it advances to the next word.
- R9: Opcode 0x0C raises `halted`, which then stays high. No further memory read or write occurs and the address bus holds still.
- R10: Opcode 0x00 and every opcode from 0x0D to 0xFF acts as a no-operation. The accumulator and memory are unchanged, no operand is read, and execution continues at the next word.
- R11: A loop program that adds 100 down to 0 into a memory word finishes with 5050 in that word and the counter word at 0xFFFF, then halts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Word address to memory (address register) |
| mem_rd | output | 1 | Read strobe; buffer register captures `mem_rdata` at the edge |
| mem_we | output | 1 | Write enable; memory stores `mem_wdata` at the edge |
| mem_wdata | output | 16 | Write data (buffer register) |
| mem_rdata | input | 16 | Combinational read data for `mem_addr` |
| halted | output | 1 | High while the core sits in the halt loop |

## Verification
The conditional jump is driven with accumulator values 0x0000, 0x7FFF, 0x8000 and 0xFFFF. A core that tests for strictly positive values, or that looks at the wrong bit, takes the wrong path at one of these values, and the result lands in the wrong memory word. Load is run with a nonzero accumulator already in place, which exposes a missing clear-before-add. Random operands for add, subtract, multiply and the logic operations catch carries and truncation. The unary operations and the undefined opcodes are checked by counting memory reads, which shows up a stray operand access or a misrouted dispatch. A reset issued in the middle of a running loop must restart fetch from word 0. After halt, the bus must stay quiet.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int OP_W   = 8;
  localparam int CAR_W  = 6;
  localparam int CW_W   = 32;
  localparam int MAX_OP = 12;

  // fixed control-store entry points
  localparam logic [CAR_W-1:0] UA_DISPATCH = CAR_W'(3);
  localparam logic [CAR_W-1:0] UA_HALT     = CAR_W'(15);
  localparam logic [CAR_W-1:0] UA_NOP      = CAR_W'(16);
  localparam logic [CAR_W-1:0] UA_STORE    = CAR_W'(20);
  localparam logic [CAR_W-1:0] UA_BIN_LO   = CAR_W'(24);
  localparam logic [CAR_W-1:0] UA_BIN_HI   = CAR_W'(47);
  localparam logic [CAR_W-1:0] UA_NOT      = CAR_W'(48);
  localparam logic [CAR_W-1:0] UA_SHR      = CAR_W'(50);
  localparam logic [CAR_W-1:0] UA_SHL      = CAR_W'(52);
  localparam logic [CAR_W-1:0] UA_JMP      = CAR_W'(54);
  localparam logic [OP_W-1:0]  NOP_OFFSET  = OP_W'(13);

  typedef enum logic [1:0] {
    SEQ_NEXT     = 2'd0,
    SEQ_JUMP     = 2'd1,
    SEQ_DISPATCH = 2'd2,
    SEQ_FETCH    = 2'd3
  } seq_e;

  typedef enum logic [3:0] {
    ALU_NONE = 4'h0,
    ALU_ADD  = 4'h3,
    ALU_SUB  = 4'h4,
    ALU_AND  = 4'h6,
    ALU_OR   = 4'h7,
    ALU_NOT  = 4'h8,
    ALU_SHR  = 4'h9,
    ALU_SHL  = 4'hA,
    ALU_MUL  = 4'hB
  } alu_e;

  typedef struct packed {
    logic [6:0] rsvd;
    seq_e       seq;
    logic       br_load;
    logic       ir_load;
    logic       mbr_from_acc;
    logic       mar_from_pc;
    logic       mar_from_mbr;
    logic       mem_wr;
    logic       mem_rd;
    alu_e       alu;
    logic       acc_clr;
    logic       pc_jcond;
    logic       pc_inc;
    logic       pc_clr;
    logic [7:0] target;
  } ctrl_t;

  // accumulator arithmetic
  function automatic logic [DATA_W-1:0] alu_calc(input alu_e op,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] prod;
    prod = a * b;
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_NOT: return ~a;
      ALU_SHR: return {1'b0, a[DATA_W-1:1]};
      ALU_SHL: return {a[DATA_W-2:0], 1'b0};
      ALU_MUL: return prod[DATA_W-1:0];
      default: return a;
    endcase
  endfunction

  // opcode to jump-table offset; undefined opcodes fall on the no-op slot
  function automatic logic [CAR_W-1:0] dispatch_offset(input logic [OP_W-1:0] op);
    if (op >= OP_W'(1) && op <= OP_W'(MAX_OP)) return op[CAR_W-1:0];
    return NOP_OFFSET[CAR_W-1:0];
  endfunction

  // jump-table entry to routine entry
  function automatic logic [CAR_W-1:0] routine_entry(input logic [CAR_W-1:0] slot);
    case (slot)
      CAR_W'(4):  return UA_STORE;
      CAR_W'(5):  return CAR_W'(24);
      CAR_W'(6):  return CAR_W'(28);
      CAR_W'(7):  return CAR_W'(32);
      CAR_W'(8):  return UA_JMP;
      CAR_W'(9):  return CAR_W'(36);
      CAR_W'(10): return CAR_W'(40);
      CAR_W'(11): return UA_NOT;
      CAR_W'(12): return UA_SHR;
      CAR_W'(13): return UA_SHL;
      CAR_W'(14): return CAR_W'(44);
      default:    return UA_HALT;
    endcase
  endfunction

  // operation of each four-step memory-operand routine group
  function automatic alu_e group_op(input logic [CAR_W-1:0] a);
    case (a[CAR_W-1:2])
      4'(6):   return ALU_ADD;   // load: clear then add
      4'(7):   return ALU_ADD;
      4'(8):   return ALU_SUB;
      4'(9):   return ALU_AND;
      4'(10):  return ALU_OR;
      default: return ALU_MUL;
    endcase
  endfunction

  // control store contents
  function automatic ctrl_t ucode(input logic [CAR_W-1:0] a);
    ctrl_t c;
    c = '0;
    if (a >= CAR_W'(4) && a <= UA_HALT) begin
      c.seq    = SEQ_JUMP;
      c.target = 8'(routine_entry(a));
    end else if (a >= UA_BIN_LO && a <= UA_BIN_HI) begin
      case (a[1:0])
        2'd0: c.mar_from_mbr = 1'b1;
        2'd1: begin
          c.mem_rd  = 1'b1;
          c.pc_inc  = 1'b1;
          c.acc_clr = (a[CAR_W-1:2] == 4'(6));
        end
        2'd2: c.br_load = 1'b1;
        default: begin
          c.alu = group_op(a);
          c.seq = SEQ_FETCH;
        end
      endcase
    end else begin
      case (a)
        CAR_W'(0): c.mar_from_pc = 1'b1;
        CAR_W'(1): c.mem_rd      = 1'b1;
        CAR_W'(2): c.ir_load     = 1'b1;
        UA_DISPATCH: c.seq       = SEQ_DISPATCH;
        UA_NOP: begin
          c.pc_inc = 1'b1;
          c.seq    = SEQ_FETCH;
        end
        UA_STORE: c.mar_from_mbr = 1'b1;
        CAR_W'(21): begin
          c.mbr_from_acc = 1'b1;
          c.pc_inc       = 1'b1;
        end
        CAR_W'(22): begin
          c.mem_wr = 1'b1;
          c.seq    = SEQ_FETCH;
        end
        UA_NOT, UA_SHR, UA_SHL: begin
          c.alu    = (a == UA_NOT) ? ALU_NOT : ((a == UA_SHR) ? ALU_SHR : ALU_SHL);
          c.pc_inc = 1'b1;
          c.seq    = SEQ_FETCH;
        end
        UA_JMP: begin
          c.pc_jcond = 1'b1;
          c.seq      = SEQ_FETCH;
        end
        default: c = '0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/acc_cpu_sequencer.sv
module acc_cpu_sequencer
  import acc_cpu_pkg::*;
#(
  parameter int SEQ_CAR_W = CAR_W,
  parameter int SEQ_OP_W  = OP_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [SEQ_OP_W-1:0]   opcode,
  output ctrl_t                 ctrl,
  output logic [SEQ_CAR_W-1:0]  car,
  output logic                  dispatch_fire,
  output logic                  halted
);

  logic [SEQ_CAR_W-1:0] car_q;
  logic [SEQ_CAR_W-1:0] car_d;

  assign ctrl          = ucode(car_q);
  assign dispatch_fire = (ctrl.seq == SEQ_DISPATCH);
  assign halted        = (car_q == UA_HALT);
  assign car           = car_q;

  always_comb begin
    unique case (ctrl.seq)
      SEQ_NEXT:     car_d = car_q + SEQ_CAR_W'(1);
      SEQ_JUMP:     car_d = ctrl.target[SEQ_CAR_W-1:0];
      SEQ_DISPATCH: car_d = car_q + dispatch_offset(opcode);
      default:      car_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) car_q <= '0;
    else     car_q <= car_d;
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int ALU_W = DATA_W
) (
  input  alu_e             op,
  input  logic [ALU_W-1:0] acc,
  input  logic [ALU_W-1:0] operand,
  output logic [ALU_W-1:0] result,
  output logic             writes_acc
);

  assign result     = alu_calc(op, acc, operand);
  assign writes_acc = (op != ALU_NONE);

endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
  import acc_cpu_pkg::*;
#(
  parameter int DP_DATA_W = DATA_W,
  parameter int DP_ADDR_W = ADDR_W,
  parameter int DP_OP_W   = OP_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  ctrl_t                ctrl,
  input  logic [DP_DATA_W-1:0] mem_rdata,
  output logic [DP_ADDR_W-1:0] pc,
  output logic [DP_ADDR_W-1:0] mar,
  output logic [DP_DATA_W-1:0] mbr,
  output logic [DP_OP_W-1:0]   ir,
  output logic [DP_DATA_W-1:0] acc,
  output logic                 jump_taken
);

  logic [DP_DATA_W-1:0] br_q;
  logic [DP_DATA_W-1:0] alu_res;
  logic                 alu_wr;

  acc_cpu_alu #(.ALU_W(DP_DATA_W)) u_alu (
    .op         (ctrl.alu),
    .acc        (acc),
    .operand    (br_q),
    .result     (alu_res),
    .writes_acc (alu_wr)
  );

  assign jump_taken = ctrl.pc_jcond && !acc[DP_DATA_W-1];

  // program counter
  always_ff @(posedge clk) begin
    if (rst || ctrl.pc_clr)             pc <= '0;
    else if (jump_taken)                pc <= mbr[DP_ADDR_W-1:0];
    else if (ctrl.pc_inc || ctrl.pc_jcond) pc <= pc + DP_ADDR_W'(1);
  end

  // accumulator
  always_ff @(posedge clk) begin
    if (rst || ctrl.acc_clr) acc <= '0;
    else if (alu_wr)         acc <= alu_res;
  end

  // address, buffer, opcode and operand registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mar  <= '0;
      mbr  <= '0;
      ir   <= '0;
      br_q <= '0;
    end else begin
      if (ctrl.mar_from_pc)       mar <= pc;
      else if (ctrl.mar_from_mbr) mar <= mbr[DP_ADDR_W-1:0];
      if (ctrl.mem_rd)            mbr <= mem_rdata;
      else if (ctrl.mbr_from_acc) mbr <= acc;
      if (ctrl.ir_load)           ir  <= mbr[DP_DATA_W-1 -: DP_OP_W];
      if (ctrl.br_load)           br_q <= mbr;
    end
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int CORE_DATA_W = DATA_W,
  parameter int CORE_ADDR_W = ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  output logic [CORE_ADDR_W-1:0] mem_addr,
  output logic                   mem_rd,
  output logic                   mem_we,
  output logic [CORE_DATA_W-1:0] mem_wdata,
  input  logic [CORE_DATA_W-1:0] mem_rdata,
  output logic                   halted
);

  ctrl_t                  ctrl;
  logic [CAR_W-1:0]       car;
  logic                   dispatch_fire;
  logic                   jump_taken;
  logic [CORE_ADDR_W-1:0] pc;
  logic [CORE_ADDR_W-1:0] mar;
  logic [CORE_DATA_W-1:0] mbr;
  logic [OP_W-1:0]        ir;
  logic [CORE_DATA_W-1:0] acc;
  logic                   jump_step;

  acc_cpu_sequencer #(.SEQ_CAR_W(CAR_W), .SEQ_OP_W(OP_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .opcode        (ir),
    .ctrl          (ctrl),
    .car           (car),
    .dispatch_fire (dispatch_fire),
    .halted        (halted)
  );

  acc_cpu_datapath #(
    .DP_DATA_W (CORE_DATA_W),
    .DP_ADDR_W (CORE_ADDR_W),
    .DP_OP_W   (OP_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .mem_rdata  (mem_rdata),
    .pc         (pc),
    .mar        (mar),
    .mbr        (mbr),
    .ir         (ir),
    .acc        (acc),
    .jump_taken (jump_taken)
  );

  assign jump_step = ctrl.pc_jcond;
  assign mem_addr  = mar;
  assign mem_rd    = ctrl.mem_rd;
  assign mem_we    = ctrl.mem_wr;
  assign mem_wdata = mbr;

endmodule

// File: rtl/acc_cpu_core_checker.sv
module acc_cpu_core_checker #(
  parameter int CK_DATA_W = 16,
  parameter int CK_ADDR_W = 8,
  parameter int CK_CAR_W  = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 mem_rd,
  input logic                 mem_we,
  input logic [CK_ADDR_W-1:0] mem_addr,
  input logic [CK_DATA_W-1:0] mem_wdata,
  input logic                 halted,
  input logic [CK_ADDR_W-1:0] pc,
  input logic [CK_DATA_W-1:0] acc,
  input logic [CK_DATA_W-1:0] mbr,
  input logic [CK_CAR_W-1:0]  car,
  input logic                 dispatch_fire,
  input logic                 jump_step
);

  logic rst_seen = 1'b0;
  always @(posedge clk) rst_seen <= rst;

  // R1: one edge after reset the architectural state is clear
  always @(posedge clk) begin
    if (rst_seen) begin
      assert_reset_clear_R1: assert (pc == '0 && acc == '0 && car == '0)
        else $error("reset did not clear state");
    end
  end

  // R2: stored data is the accumulator
  assert_store_acc_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == acc));

  // R8: jump with bit 15 clear takes the address field
  assert_jump_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (jump_step && !acc[CK_DATA_W-1]) |=> (pc == $past(mbr[CK_ADDR_W-1:0])));

  // R8: jump with bit 15 set falls through
  assert_jump_fall_R8: assert property (@(posedge clk) disable iff (rst)
    (jump_step && acc[CK_DATA_W-1]) |=> (pc == $past(pc) + CK_ADDR_W'(1)));

  // R9: halt is sticky and the bus is idle
  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_we && !mem_rd && $stable(mem_addr) && $stable(pc)));

  // R10: dispatch always lands inside the jump table
  assert_dispatch_range_R10: assert property (@(posedge clk) disable iff (rst)
    dispatch_fire |=> (car >= CK_CAR_W'(4) && car <= CK_CAR_W'(16)));

  // R2: never read and write in the same cycle
  assert_bus_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_rd));

endmodule

bind acc_cpu_core acc_cpu_core_checker #(
  .CK_DATA_W (CORE_DATA_W),
  .CK_ADDR_W (CORE_ADDR_W),
  .CK_CAR_W  (acc_cpu_pkg::CAR_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mem_rd        (mem_rd),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .halted        (halted),
  .pc            (pc),
  .acc           (acc),
  .mbr           (mbr),
  .car           (car),
  .dispatch_fire (dispatch_fire),
  .jump_step     (jump_step)
);

// File: tb/test_acc_cpu_core.sv
module test_acc_cpu_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_addr;
  logic        mem_rd;
  logic        mem_we;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        halted;

  logic [15:0] mem [256];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int n_rd, n_wr;
  bit done;

  always #5 clk = ~clk;

  acc_cpu_core i_acc_cpu_core (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run did not end, actual cycles=%0d expected below 150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference model for operand instructions
  function automatic int ref_op(input int op, input int a, input int b);
    longint p;
    case (op)
      2:  return b;
      3:  return (a + b) % 65536;
      4:  return (a - b + 65536) % 65536;
      6:  return a & b;
      7:  return a | b;
      8:  return 65535 - a;
      9:  return a / 2;
      10: return (a * 2) % 65536;
      default: begin
        p = longint'(a) * longint'(b);
        return int'(p % 65536);
      end
    endcase
  endfunction

  function automatic string req_of(input int op);
    case (op)
      2: return "R3";
      3, 4: return "R4";
      6, 7: return "R5";
      8, 9, 10: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_prog(input int limit);
    int k;
    do_reset();
    n_rd = 0;
    n_wr = 0;
    k = 0;
    done = 1'b0;
    while (k < limit) begin
      @(negedge clk);
      k++;
      if (mem_rd) n_rd++;
      if (mem_we) n_wr++;
      if (halted) begin
        done = 1'b1;
        break;
      end
    end
    check(done, "R9", "program reached halt", int'(done), 1);
  endtask

  // LOAD 80 ; OP 81 ; STORE 82 ; HALT
  task automatic binary_case(input int op, input logic [15:0] a, input logic [15:0] b);
    int exp;
    clear_mem();
    mem[0] = 16'h0280;
    mem[1] = {8'(op), 8'h81};
    mem[2] = 16'h0182;
    mem[3] = 16'h0C00;
    mem[8'h80] = a;
    mem[8'h81] = b;
    run_prog(400);
    exp = (op == 2) ? ref_op(op, ref_op(2, 0, int'(a)), int'(b)) : ref_op(op, int'(a), int'(b));
    check(int'(mem[8'h82]) == exp, req_of(op), "binary result", int'(mem[8'h82]), exp);
    check(n_wr == 1, "R2", "one store write", n_wr, 1);
  endtask

  // LOAD 80 ; UNARY 82 ; STORE 82 ; HALT
  task automatic unary_case(input int op, input logic [15:0] a);
    int exp;
    clear_mem();
    mem[0] = 16'h0280;
    mem[1] = {8'(op), 8'h82};
    mem[2] = 16'h0182;
    mem[3] = 16'h0C00;
    mem[8'h80] = a;
    mem[8'h82] = 16'h5A5A;
    run_prog(400);
    exp = ref_op(op, int'(a), 0);
    check(int'(mem[8'h82]) == exp, "R6", "unary result", int'(mem[8'h82]), exp);
    check(n_rd == 5, "R6", "no operand read for unary", n_rd, 5);
  endtask

  // LOAD 80 ; JMP 04 ; STORE 82 ; HALT ; STORE 83 ; HALT
  task automatic jump_case(input logic [15:0] a);
    bit take;
    clear_mem();
    mem[0] = 16'h0280;
    mem[1] = 16'h0504;
    mem[2] = 16'h0182;
    mem[3] = 16'h0C00;
    mem[4] = 16'h0183;
    mem[5] = 16'h0C00;
    mem[8'h80] = a;
    mem[8'h82] = 16'hDEAD;
    mem[8'h83] = 16'hDEAD;
    run_prog(400);
    take = (a < 16'h8000);
    check(int'(mem[8'h83]) == (take ? int'(a) : 'hDEAD), "R8", "taken path word",
          int'(mem[8'h83]), take ? int'(a) : 'hDEAD);
    check(int'(mem[8'h82]) == (take ? 'hDEAD : int'(a)), "R8", "fall path word",
          int'(mem[8'h82]), take ? 'hDEAD : int'(a));
  endtask

  task automatic load_sum_prog();
    clear_mem();
    mem[0]  = 16'h02A0; mem[1]  = 16'h01A4; mem[2]  = 16'h02A2; mem[3]  = 16'h01A3;
    mem[4]  = 16'h02A4; mem[5]  = 16'h03A3; mem[6]  = 16'h01A4; mem[7]  = 16'h02A3;
    mem[8]  = 16'h04A1; mem[9]  = 16'h01A3; mem[10] = 16'h0504; mem[11] = 16'h0C00;
    mem[8'hA0] = 16'd0;
    mem[8'hA1] = 16'd1;
    mem[8'hA2] = 16'd100;
  endtask

  initial begin
    int ops[6];
    logic [7:0] a0;
    ops = '{2, 3, 4, 6, 7, 11};
    void'($urandom(32'h00C0FFEE));

    // R1: reset state and first fetch, also after a reset mid-run
    load_sum_prog();
    do_reset();
    check(!mem_we && !halted, "R1", "quiet right after reset", int'(mem_we), 0);
    @(negedge clk);
    check(mem_rd && mem_addr == 8'h00, "R1", "first fetch from word 0", int'(mem_addr), 0);
    repeat (500) @(negedge clk);
    do_reset();
    @(negedge clk);
    check(mem_rd && mem_addr == 8'h00, "R1", "fetch from word 0 after mid-run reset",
          int'(mem_addr), 0);

    // R11: sum 100 down to 0
    load_sum_prog();
    run_prog(20000);
    check(mem[8'hA4] == 16'd5050, "R11", "sum word", int'(mem[8'hA4]), 5050);
    check(mem[8'hA3] == 16'hFFFF, "R11", "counter word", int'(mem[8'hA3]), 'hFFFF);

    // R9: bus idle and halt sticky after halt
    a0 = mem_addr;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      check(halted && !mem_rd && !mem_we && mem_addr == a0, "R9", "idle after halt",
            int'(mem_addr), int'(a0));
    end

    // R3 with a nonzero accumulator beforehand: LOAD 81 ; LOAD 80 ; STORE 82 ; HALT
    clear_mem();
    mem[0] = 16'h0281; mem[1] = 16'h0280; mem[2] = 16'h0182; mem[3] = 16'h0C00;
    mem[8'h80] = 16'h0F0F; mem[8'h81] = 16'hF0F3;
    run_prog(400);
    check(mem[8'h82] == 16'h0F0F, "R3", "load replaces accumulator", int'(mem[8'h82]), 'h0F0F);

    // directed corners
    binary_case(3, 16'hFFFF, 16'h0001);   // R4 wrap
    binary_case(4, 16'h0000, 16'h0001);   // R4 borrow
    binary_case(11, 16'h1234, 16'h5678);  // R7 truncation
    binary_case(11, 16'hFFFF, 16'hFFFF);  // R7
    unary_case(8, 16'h00FF);
    unary_case(9, 16'h8001);
    unary_case(10, 16'h8001);
    jump_case(16'h0000);
    jump_case(16'h7FFF);
    jump_case(16'h8000);
    jump_case(16'hFFFF);

    // random operand instructions
    for (int t = 0; t < 24; t++) begin
      binary_case(ops[$urandom % 6], 16'($urandom), 16'($urandom));
    end
    for (int t = 0; t < 6; t++) begin
      unary_case(8 + int'($urandom % 3), 16'($urandom));
      jump_case(16'($urandom));
    end

    // R10: undefined opcodes: LOAD 80 ; 00 80 ; FF 81 ; 0D 81 ; STORE 82 ; HALT
    clear_mem();
    mem[0] = 16'h0280; mem[1] = 16'h0080; mem[2] = 16'hFF81; mem[3] = 16'h0D81;
    mem[4] = 16'h0182; mem[5] = 16'h0C00;
    mem[8'h80] = 16'h3C3C; mem[8'h81] = 16'h1111;
    run_prog(600);
    check(mem[8'h82] == 16'h3C3C, "R10", "accumulator kept", int'(mem[8'h82]), 'h3C3C);
    check(mem[8'h80] == 16'h3C3C && mem[8'h81] == 16'h1111, "R10", "memory untouched",
          int'(mem[8'h81]), 'h1111);
    check(n_rd == 7, "R10", "no operand reads", n_rd, 7);
    check(n_wr == 1, "R10", "single write", n_wr, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule